// File: doc/BRIEF.md
# LFSR Noise Voice

This block produces the noise voice of a retro sound unit. A 15-bit linear feedback shift register is advanced by a programmable period timer. Each advance yields one pseudo-random bit. While the voice is active, that bit decides whether the externally supplied 4-bit volume or zero appears on the 4-bit sample output. The step period comes from a small table of base divisors, shifted left by a programmable amount. A short mode folds the feedback into bit 6 as well, so the sequence repeats after 127 steps instead of 32767.

The host writes a configuration byte that selects the period and the width mode. It writes two control flags to start the voice and to choose whether length expiry silences it. It may also preload a 6-bit length count that an external length strobe advances. Timer and register progress happen only on cycles where the cycle-enable input is high. The envelope, the mixing and the panning live outside this block.

Top module: `noise_voice`

## Requirements
- R1: After reset, `active` is 0 and `sample_out` is 0.
- R2: In `cfg_byte`, bits 2:0 are the divisor code, bit 3 is short mode and bits 7:4 are the shift amount. Code 0 gives base 8 and code c (1..7) gives base 16*c. The step period is the base shifted left by the shift amount, counted in enabled cycles.
- R3: `ctl_wr` with `ctl_flags[1]` set triggers the voice. On the next edge `active` is 1, the register is seeded with 0x7FF1 and the timer is reloaded. The first step happens on the period-th enabled edge after the trigger edge, and the output stays 0 until then.
- R4: On each step the feedback bit is bit 0 XOR bit 1. The register shifts right by one and the feedback enters bit 14.
- R5: In short mode the feedback bit also replaces bit 6 after the shift.
- R6: `sample_out` equals the present `vol_in` when `active` is 1 and the last feedback bit is 1; otherwise it is 0. A change of `vol_in` shows on the output without delay.
- R7: While `cyc_en` is low, neither the timer nor the register advances, so the step is delayed by exactly the number of disabled cycles.
- R8: `len_wr` loads `len_val` into the length count. Each `len_tick` adds one, and a tick at 63 wraps the count to 0. When the length-stop flag is set, that wrap clears `active`. The flag is `ctl_flags[0]` and is captured on every `ctl_wr`.
- R9: With the length-stop flag clear, a wrap leaves `active` unchanged.
- R10: While `active` is 0, `sample_out` stays 0 whatever the volume, and a new trigger restarts the sequence from the seed.
- R11: A trigger in the same cycle as a stopping wrap leaves `active` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Per-cycle enable for timer and register |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_byte | input | 8 | Divisor code, short mode, shift amount |
| ctl_wr | input | 1 | Control write strobe |
| ctl_flags | input | 2 | [1] trigger, [0] length-stop |
| len_wr | input | 1 | Length count load strobe |
| len_val | input | 6 | Length count load value |
| vol_in | input | 4 | Volume from the envelope |
| len_tick | input | 1 | Length counter advance strobe |
| sample_out | output | 4 | Noise sample |
| active | output | 1 | Voice active flag |

## Verification
The hardest case to reach is a deviation deep in the register sequence. It includes the short-mode fold into bit 6, which only changes the output after many steps. The bench reaches it in two ways. It sweeps every divisor code, three shift amounts and both width modes, comparing every cycle against an arithmetic model of the register. It also runs several hundred consecutive steps at the shortest period, so the whole 127-step short cycle and a long stretch of the full sequence are compared bit for bit. Length expiry is reached by preloading the count close to its wrap point rather than ticking it from zero.

// File: rtl/noise_voice.sv
module noise_voice #(
  parameter int LFSR_W    = 15,
  parameter int SEED      = 32'h7FF1,
  parameter int SHORT_TAP = 6,
  parameter int LEN_W     = 6,
  parameter int VOL_W     = 4,
  parameter int CODE_W    = 3,
  parameter int SHIFT_W   = 4,
  parameter int BASE_W    = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cyc_en,
  input  logic                            cfg_wr,
  input  logic [CODE_W+SHIFT_W:0]         cfg_byte,
  input  logic                            ctl_wr,
  input  logic [1:0]                      ctl_flags,
  input  logic                            len_wr,
  input  logic [LEN_W-1:0]                len_val,
  input  logic [VOL_W-1:0]                vol_in,
  input  logic                            len_tick,
  output logic [VOL_W-1:0]                sample_out,
  output logic                            active
);
  localparam int TMR_W = BASE_W + (1 << SHIFT_W) - 1;

  logic [CODE_W-1:0]  code_q;
  logic               short_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [TMR_W-1:0]   timer;
  logic [LFSR_W-1:0]  lfsr;
  logic               out_bit;
  logic [LEN_W-1:0]   len_cnt;
  logic               len_en;

  logic               trig;
  logic               step;
  logic               fb;
  logic               wrap;
  logic [BASE_W-1:0]  base;
  logic [TMR_W-1:0]   reload;
  logic [LFSR_W-1:0]  lfsr_nxt;

  assign trig   = ctl_wr & ctl_flags[1];
  assign base   = (code_q == '0) ? BASE_W'(8) : (BASE_W'(code_q) << 4);
  assign reload = TMR_W'(base) << shift_q;
  assign step   = cyc_en & (timer <= TMR_W'(1));
  assign fb     = lfsr[0] ^ lfsr[1];
  assign wrap   = len_tick & ~len_wr & (len_cnt == '1);

  always_comb begin
    lfsr_nxt = {fb, lfsr[LFSR_W-1:1]};
    if (short_q) lfsr_nxt[SHORT_TAP] = fb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      short_q <= 1'b0;
      shift_q <= '0;
    end else if (cfg_wr) begin
      code_q  <= cfg_byte[CODE_W-1:0];
      short_q <= cfg_byte[CODE_W];
      shift_q <= cfg_byte[CODE_W+SHIFT_W:CODE_W+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        timer <= '0;
    else if (trig)     timer <= reload;
    else if (step)     timer <= reload;
    else if (cyc_en)   timer <= timer - TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= '0;
      out_bit <= 1'b0;
    end else if (trig) begin
      lfsr    <= LFSR_W'(SEED);
      out_bit <= 1'b0;
    end else if (step && active) begin
      lfsr    <= lfsr_nxt;
      out_bit <= fb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        len_cnt <= '0;
    else if (len_wr)   len_cnt <= len_val;
    else if (len_tick) len_cnt <= len_cnt + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      len_en <= 1'b0;
    else if (ctl_wr) len_en <= ctl_flags[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                active <= 1'b0;
    else if (trig)             active <= 1'b1;
    else if (wrap && len_en)   active <= 1'b0;
  end

  assign sample_out = (active && out_bit) ? vol_in : '0;
endmodule

// File: rtl/noise_voice_chk.sv
module noise_voice_chk #(
  parameter int LFSR_W  = 15,
  parameter int SEED    = 32'h7FF1,
  parameter int LEN_W   = 6,
  parameter int VOL_W   = 4,
  parameter int TMR_W   = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_en,
  input logic              trig,
  input logic              len_wr,
  input logic              len_tick,
  input logic [LEN_W-1:0]  len_cnt,
  input logic              len_en,
  input logic [LFSR_W-1:0] lfsr,
  input logic [TMR_W-1:0]  timer,
  input logic [VOL_W-1:0]  sample_out,
  input logic              active
);
  assert_trigger_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (active && lfsr == LFSR_W'(SEED)));

  assert_gated_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !trig) |=> ($stable(lfsr) && $stable(timer)));

  assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (lfsr != '0));

  assert_silent_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out != '0) |-> active);

  assert_length_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (len_tick && !len_wr && len_cnt == '1 && len_en && !trig) |=> !active);

  assert_length_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !len_en && !trig) |=> active);

  assert_trigger_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && len_tick && len_cnt == '1) |=> active);
endmodule

bind noise_voice noise_voice_chk #(
  .LFSR_W(LFSR_W), .SEED(SEED), .LEN_W(LEN_W), .VOL_W(VOL_W), .TMR_W(TMR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .trig(trig), .len_wr(len_wr),
  .len_tick(len_tick), .len_cnt(len_cnt), .len_en(len_en), .lfsr(lfsr),
  .timer(timer), .sample_out(sample_out), .active(active)
);

// File: tb/noise_voice_tb_top.sv
module noise_voice_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_byte = '0;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_flags = '0;
  logic       len_wr = 1'b0;
  logic [5:0] len_val = '0;
  logic [3:0] vol_in = '0;
  logic       len_tick = 1'b0;
  logic [3:0] sample_out;
  logic       active;

  int total = 0;
  int bad = 0;

  logic [14:0] m_lfsr;
  logic        m_out;
  logic        m_short;
  logic        m_active;
  int          m_cnt;

  always #2 clk = ~clk;

  noise_voice dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .ctl_wr(ctl_wr), .ctl_flags(ctl_flags), .len_wr(len_wr), .len_val(len_val),
    .vol_in(vol_in), .len_tick(len_tick), .sample_out(sample_out), .active(active)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic f;
    f = m_lfsr[0] ^ m_lfsr[1];
    m_lfsr = {f, m_lfsr[14:1]};
    if (m_short) m_lfsr[6] = f;
    m_out = f;
  endtask

  function automatic int period_of(input int code, input int sh);
    int b;
    b = (code == 0) ? 8 : 16 * code;
    return b << sh;
  endfunction

  task automatic write_cfg(input int code, input bit shrt, input int sh);
    @(negedge clk);
    cfg_byte = {sh[3:0], shrt, code[2:0]};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_short = shrt;
  endtask

  task automatic trigger(input bit lstop);
    @(negedge clk);
    ctl_flags = {1'b1, lstop};
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_flags = '0;
    m_lfsr = 15'h7FF1;
    m_out = 1'b0;
    m_cnt = 0;
    m_active = 1'b1;
  endtask

  task automatic run(input string req, input int cycles, input int per, input int pat);
    for (int i = 0; i < cycles; i++) begin
      bit en;
      en = (pat == 0) ? 1'b1 : ((i % pat) == 0);
      cyc_en = en;
      @(negedge clk);
      if (en) begin
        m_cnt++;
        if (m_cnt == per) begin
          if (m_active) model_step();
          m_cnt = 0;
        end
      end
      check(req, sample_out, (m_active && m_out) ? vol_in : 0);
    end
    cyc_en = 1'b0;
  endtask

  task automatic len_load(input int v);
    @(negedge clk);
    len_val = v[5:0];
    len_wr = 1'b1;
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    len_tick = 1'b1;
    @(negedge clk);
    len_tick = 1'b0;
  endtask

  initial begin
    #700000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_short = 0; m_active = 0; m_out = 0; m_lfsr = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 active", active, 0);
    check("R1 sample", sample_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 active after release", active, 0);

    // R2 R3 R4 R5 R6: sweep of all divisor codes, three shifts, both widths
    for (int code = 0; code < 8; code++)
      for (int sh = 0; sh < 3; sh++)
        for (int w = 0; w < 2; w++) begin
          write_cfg(code, w[0], sh);
          vol_in = 4'((code + sh + w) % 15 + 1);
          trigger(1'b0);
          check("R3 active after trigger", active, 1);
          check("R3 silent before first step", sample_out, 0);
          run("R2 period/R4 R5 sequence", period_of(code, sh) * 6, period_of(code, sh), 0);
        end

    // R4 long sequence, R5 full short cycle
    write_cfg(0, 1'b0, 0);
    vol_in = 4'd9;
    trigger(1'b0);
    run("R4 long sequence", 8 * 300, 8, 0);
    write_cfg(0, 1'b1, 0);
    vol_in = 4'd5;
    trigger(1'b0);
    run("R5 short sequence", 8 * 260, 8, 0);

    // R6 volume passes through immediately
    vol_in = 4'd15;
    @(negedge clk);
    check("R6 immediate volume", sample_out, m_out ? 15 : 0);
    vol_in = 4'd3;
    @(negedge clk);
    check("R6 immediate volume", sample_out, m_out ? 3 : 0);

    // R7 gating: enabled on every third cycle, and long disabled hold
    write_cfg(1, 1'b0, 0);
    vol_in = 4'd7;
    trigger(1'b0);
    run("R7 gated timing", 16 * 3 * 5, 16, 3);
    trigger(1'b0);
    repeat (60) begin
      @(negedge clk);
      check("R7 hold while disabled", sample_out, 0);
    end
    run("R7 first step after hold", 16, 16, 0);
    check("R7 first step seen", sample_out, 7);

    // R8 length stop
    trigger(1'b1);
    len_load(60);
    tick(); tick(); tick();
    check("R8 still active at 63", active, 1);
    tick();
    check("R8 stopped on wrap", active, 0);
    // R10 silent when inactive
    vol_in = 4'd12;
    m_active = 1'b0;
    run("R10 silent while inactive", 200, 16, 0);
    check("R10 inactive flag", active, 0);
    trigger(1'b0);
    run("R10 retrigger restarts", 16 * 4, 16, 0);

    // R8 count wrapped to 0: 63 ticks keep active, 64th stops
    trigger(1'b1);
    len_load(0);
    for (int k = 0; k < 63; k++) tick();
    check("R8 active before 64th tick", active, 1);
    tick();
    check("R8 stop after 64 ticks", active, 0);

    // R9 length stop clear
    trigger(1'b0);
    len_load(62);
    tick(); tick(); tick();
    check("R9 wrap ignored", active, 1);
    vol_in = 4'd6;
    run("R9 output continues", 16 * 3, 16, 0);

    // R11 trigger wins over stopping wrap
    trigger(1'b1);
    len_load(63);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_flags = 2'b11;
    len_tick = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_flags = '0;
    len_tick = 1'b0;
    m_lfsr = 15'h7FF1; m_out = 0; m_cnt = 0; m_active = 1;
    check("R11 trigger wins", active, 1);
    check("R11 restarted silent", sample_out, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule